// File: doc/BRIEF.md
# Single-Pin Input Debounce and Event Controller

This block manages one general-purpose pad. The raw pad level is brought into the core clock domain by a short synchronizer chain. It then passes through a programmable debounce filter. An event detector watches the filtered level for either a level condition or an edge condition, with selectable polarity. Detected events can set a sticky interrupt status flag, drive an interrupt line, and set a sticky wake flag. The wake flag is fanned out to three sleep-state request lines, and each line is gated by its own enable.

Software reaches the block through one 32-bit control word. Writing the word stores the configuration fields. Reading it returns those fields together with the filtered pin level and the two status flags. The same word also holds the output value, the output enable and the pull-resistor selection, which are exported to the pad ring unchanged.

Top module: `pad_evt_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0 while the pad is low, and `irq_out`, `wake_req`, `pad_out`, `pad_oe` and `pull_cfg` are all 0.
- R2: A write stores bits 15:0 and 23:19 and reads them back unchanged. Bits 31:30, 27:24 and 18:17 read 0. `pad_out` follows bit 22, `pad_oe` follows bit 23, and `pull_cfg` follows bits 21:19.
- R3: The pad passes through two synchronizer flops. When the debounce count in bits 3:0 is 0, or the glitch mode in bits 6:5 is 0, the filter is bypassed. In that case a pad change appears in read bit 16 on the third rising clock edge after it.
- R4: Otherwise the filtered level (bit 16) takes a new synchronized value only after that value has held for count × M × TICK_CYC cycles. M is 1, MUL_B, MUL_C or MUL_D for {bit 7, bit 4} = 00, 01, 10 or 11. Shorter pulses are dropped when the glitch mode is 3.
- R5: In glitch mode 1, a falling input passes to bit 16 at once and only rising changes are debounced. Glitch mode 2 is the mirror case: rising passes at once and falling is debounced.
- R6: Bit 8 set selects level trigger and clear selects edge trigger. Bits 10:9 select polarity. For edges, 0 = rising, 1 = falling, 2 or 3 = both. For levels, 1 = active low and any other value = active high. An event sets the sticky interrupt status (bit 28) only while bit 11 is set.
- R7: `irq_out` is high exactly when bit 12 is set and either the interrupt status is set or an event is active in the current cycle. Delivery works with or without bit 11.
- R8: Writing 1 to bit 28 or bit 29 clears that flag, and the clear wins in its own cycle. Writing 0 leaves the flag unchanged. A level event that is still active sets the flag again one cycle later.
- R9: An event sets the sticky wake status (bit 29) when any of bits 15:13 is set. `wake_req[i]` equals the wake status ANDed with bit 13+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read view of configuration, pin level and status |
| pad_in | input | 1 | Raw asynchronous pad level |
| pad_out | output | 1 | Output value to the pad driver |
| pad_oe | output | 1 | Output enable to the pad driver |
| pull_cfg | output | 3 | Pull-resistor selection |
| irq_out | output | 1 | Interrupt delivery line |
| wake_req | output | 3 | Per-sleep-state wake requests |

## Verification
The bench samples the filtered level one cycle before and one cycle after the exact debounce deadline. A filter that is off by a tick, or that ignores the timebase bits, therefore reads the wrong level. Single-cycle pulses are applied in each glitch mode. A design with the pass-through polarity reversed would either lose the kept glitch or let the other polarity through. The clear of a status flag under an active level is sampled in the write cycle and in the cycle after it, so a design that lets the set win, or that never re-sets, shows a wrong bit 28. Status-only, delivery-only and wake-disabled settings check that each enable gates only its own path.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // Bits of the control word that are stored as configuration.
  localparam logic [31:0] CFG_MASK = 32'h00F8_FFFF;

  // Debounce hold time in core cycles: count x timebase multiplier x cycles per tick.
  function automatic logic [31:0] deb_limit(input logic [7:0] deb,
                                            input int unsigned tick,
                                            input int unsigned m_b,
                                            input int unsigned m_c,
                                            input int unsigned m_d);
    int unsigned mult;
    case ({deb[7], deb[4]})
      2'b00:   mult = 1;
      2'b01:   mult = m_b;
      2'b10:   mult = m_c;
      default: mult = m_d;
    endcase
    return 32'(32'(deb[3:0]) * mult * tick);
  endfunction

  // Event condition from the current and previous filtered level.
  function automatic logic evt_cond(input logic lvl_mode, input logic [1:0] pol,
                                    input logic cur, input logic prev);
    if (lvl_mode) return (pol == 2'd1) ? !cur : cur;
    case (pol)
      2'd0:    return cur && !prev;
      2'd1:    return !cur && prev;
      default: return cur != prev;
    endcase
  endfunction

endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdc_filter.sv
module pdc_filter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s,
  input  logic [CNT_W-1:0] limit,
  input  logic [1:0]       mode,
  output logic             filt
);
  logic [CNT_W-1:0] cnt;
  logic bypass, fast, expire;

  assign bypass = (limit == '0) || (mode == 2'd0);
  // mode 1 keeps low glitches (falling passes), mode 2 keeps high glitches.
  assign fast   = ((mode == 2'd1) && !s) || ((mode == 2'd2) && s);
  assign expire = (cnt + 1'b1) >= limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b0;
      cnt  <= '0;
    end else if (s == filt) begin
      cnt <= '0;
    end else if (bypass || fast || expire) begin
      filt <= s;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdc_evt.sv
module pdc_evt
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       lvl_mode,
  input  logic [1:0] pol,
  output logic       hit
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  assign hit = evt_cond(lvl_mode, pol, lvl, prev);
endmodule

// File: rtl/pad_evt_ctrl.sv
module pad_evt_ctrl
  import pdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_CYC    = 7625,
  parameter int MUL_B       = 3,
  parameter int MUL_C       = 255,
  parameter int MUL_D       = 1024,
  parameter int CNT_W       = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pad_in,
  output logic        pad_out,
  output logic        pad_oe,
  output logic [2:0]  pull_cfg,
  output logic        irq_out,
  output logic [2:0]  wake_req
);
  localparam int STS_INT = 28;
  localparam int STS_WK  = 29;

  logic [31:0] cfg_q;
  logic        int_sts, wake_sts;
  logic        s_sync, filt_lvl, evt_hit;
  logic        set_int, set_wk, clr_int, clr_wk;
  logic [CNT_W-1:0] deb_cycles;
  logic        unused_wbits;

  // Configuration storage
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (reg_wr) cfg_q <= reg_wdata & CFG_MASK;

  pdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(s_sync)
  );

  assign deb_cycles = CNT_W'(deb_limit(cfg_q[7:0], TICK_CYC, MUL_B, MUL_C, MUL_D));

  pdc_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .s(s_sync), .limit(deb_cycles),
    .mode(cfg_q[6:5]), .filt(filt_lvl)
  );

  pdc_evt u_evt (
    .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .lvl_mode(cfg_q[8]),
    .pol(cfg_q[10:9]), .hit(evt_hit)
  );

  // Sticky status with write-one-to-clear; clear has priority
  assign set_int = evt_hit && cfg_q[11];
  assign set_wk  = evt_hit && (|cfg_q[15:13]);
  assign clr_int = reg_wr && reg_wdata[STS_INT];
  assign clr_wk  = reg_wr && reg_wdata[STS_WK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_sts  <= 1'b0;
      wake_sts <= 1'b0;
    end else begin
      int_sts  <= clr_int ? 1'b0 : (int_sts  || set_int);
      wake_sts <= clr_wk  ? 1'b0 : (wake_sts || set_wk);
    end
  end

  assign irq_out  = cfg_q[12] && (int_sts || evt_hit);
  assign wake_req = {3{wake_sts}} & cfg_q[15:13];
  assign pad_out  = cfg_q[22];
  assign pad_oe   = cfg_q[23];
  assign pull_cfg = cfg_q[21:19];

  assign reg_rdata = {2'b00, wake_sts, int_sts, 4'b0000, cfg_q[23:19],
                      2'b00, filt_lvl, cfg_q[15:0]};

  assign unused_wbits = ^{cfg_q[31:24], cfg_q[18:16]};
endmodule

// File: rtl/pad_evt_ctrl_chk.sv
module pad_evt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq_out,
  input logic [2:0]  wake_req,
  input logic        sync_q,
  input logic        pin_lvl
);
  // R4: the filtered level only ever moves to the synchronized value
  p_filt_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl != $past(pin_lvl)) |-> (pin_lvl == $past(sync_q)));

  // R6: interrupt status can only rise while status latching was enabled
  p_sts_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[28]) |-> $past(reg_rdata[11]));

  // R7: delivery line needs the delivery enable
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> reg_rdata[12]);

  // R8: clear wins in its own cycle
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[28]) |=> !reg_rdata[28]);

  // R8: status holds without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[28] && !(reg_wr && reg_wdata[28])) |=> reg_rdata[28]);

  // R9: a wake request needs wake status and a matching enable
  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_req) |-> (reg_rdata[29] && (|reg_rdata[15:13])));
endmodule

bind pad_evt_ctrl pad_evt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_out(irq_out), .wake_req(wake_req),
  .sync_q(s_sync), .pin_lvl(filt_lvl)
);

// File: tb/pad_evt_ctrl_tb.sv
module pad_evt_ctrl_tb;
  localparam int TICK = 2;
  localparam int MB   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pad_in = 1'b0;
  logic        pad_out, pad_oe, irq_out;
  logic [2:0]  pull_cfg, wake_req;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pad_evt_ctrl #(.TICK_CYC(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_cfg(pull_cfg), .irq_out(irq_out), .wake_req(wake_req)
  );

  // Control word fields
  localparam logic [31:0] B_TB183 = 32'h10;
  localparam logic [31:0] B_LVL   = 32'h100;
  localparam logic [31:0] B_STS   = 32'h800;
  localparam logic [31:0] B_DLV   = 32'h1000;
  localparam logic [31:0] C_INT   = 32'h1000_0000;
  localparam logic [31:0] C_WK    = 32'h2000_0000;

  function automatic logic [31:0] mk(input int cnt, input int gmode, input int pol);
    return 32'(cnt & 15) | (32'(gmode & 3) << 5) | (32'(pol & 3) << 9);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pad(input logic v);
    @(negedge clk); pad_in = v;
  endtask

  task automatic t_reset;
    chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
    chk({irq_out, wake_req, pad_out, pad_oe, pull_cfg} == '0, "R1 outputs",
        32'({irq_out, wake_req, pad_out, pad_oe, pull_cfg}), 32'h0);
  endtask

  task automatic t_regs;
    wr(32'hFFFF_FFFF);
    chk(reg_rdata == 32'h00F8_FFFF, "R2 readback", reg_rdata, 32'h00F8_FFFF);
    chk({pad_out, pad_oe, pull_cfg} == 5'b11111, "R2 pad fields",
        32'({pad_out, pad_oe, pull_cfg}), 32'h1F);
    wr(32'h0040_0000 | (32'h2 << 19));
    chk({pad_out, pad_oe, pull_cfg} == 5'b10010, "R2 out value only",
        32'({pad_out, pad_oe, pull_cfg}), 32'h12);
    wr(C_INT | C_WK);
    chk(reg_rdata == 32'h0, "R2 cleared", reg_rdata, 32'h0);
  endtask

  task automatic t_bypass;
    wr(mk(0, 3, 0));
    set_pad(1'b1);
    cyc(2);
    chk(reg_rdata[16] == 1'b0, "R3 before third edge", 32'(reg_rdata[16]), 32'h0);
    cyc(1);
    chk(reg_rdata[16] == 1'b1, "R3 third edge", 32'(reg_rdata[16]), 32'h1);
    wr(mk(5, 0, 0));
    set_pad(1'b0);
    cyc(3);
    chk(reg_rdata[16] == 1'b0, "R3 glitch mode 0 bypass", 32'(reg_rdata[16]), 32'h0);
  endtask

  task automatic t_debounce;
    int lim;
    lim = 3 * TICK;
    wr(mk(3, 3, 0));
    set_pad(1'b1);
    cyc(lim + 1);
    chk(reg_rdata[16] == 1'b0, "R4 early", 32'(reg_rdata[16]), 32'h0);
    cyc(1);
    chk(reg_rdata[16] == 1'b1, "R4 deadline", 32'(reg_rdata[16]), 32'h1);
    lim = 2 * MB * TICK;
    wr(mk(2, 3, 0) | B_TB183);
    set_pad(1'b0);
    cyc(lim + 1);
    chk(reg_rdata[16] == 1'b1, "R4 timebase early", 32'(reg_rdata[16]), 32'h1);
    cyc(1);
    chk(reg_rdata[16] == 1'b0, "R4 timebase deadline", 32'(reg_rdata[16]), 32'h0);
    wr(mk(3, 3, 0));
    set_pad(1'b1);
    cyc(2);
    set_pad(1'b0);
    cyc(12);
    chk(reg_rdata[16] == 1'b0, "R4 short pulse dropped", 32'(reg_rdata[16]), 32'h0);
  endtask

  task automatic pulse(input logic v);
    set_pad(v);
    set_pad(!v);
  endtask

  task automatic t_glitch;
    wr(mk(3, 1, 0));
    set_pad(1'b1);
    cyc(20);
    pulse(1'b0);
    cyc(3);
    chk(reg_rdata[16] == 1'b0, "R5 mode1 low glitch kept", 32'(reg_rdata[16]), 32'h0);
    set_pad(1'b0);
    cyc(20);
    pulse(1'b1);
    cyc(3);
    chk(reg_rdata[16] == 1'b0, "R5 mode1 high glitch dropped", 32'(reg_rdata[16]), 32'h0);
    wr(mk(3, 2, 0));
    cyc(5);
    pulse(1'b1);
    cyc(3);
    chk(reg_rdata[16] == 1'b1, "R5 mode2 high glitch kept", 32'(reg_rdata[16]), 32'h1);
    cyc(20);
  endtask

  task automatic t_edge(input int pol, input logic from, input logic en,
                        input logic exp, input string tag);
    logic [31:0] c;
    c = mk(0, 3, pol) | (en ? B_STS : 32'h0);
    wr(c | C_INT);
    set_pad(from);
    cyc(8);
    wr(c | C_INT);
    cyc(2);
    set_pad(!from);
    cyc(6);
    chk(reg_rdata[28] == exp, tag, 32'(reg_rdata[28]), 32'(exp));
  endtask

  task automatic t_trig;
    t_edge(0, 1'b0, 1'b1, 1'b1, "R6 rising edge");
    t_edge(0, 1'b1, 1'b1, 1'b0, "R6 rising ignores fall");
    t_edge(1, 1'b1, 1'b1, 1'b1, "R6 falling edge");
    t_edge(2, 1'b1, 1'b1, 1'b1, "R6 both edges fall");
    t_edge(2, 1'b0, 1'b1, 1'b1, "R6 both edges rise");
    t_edge(0, 1'b0, 1'b0, 1'b0, "R6 status disabled");
  endtask

  task automatic t_w1c;
    // pad is high here; level-high trigger re-sets after clear
    wr(mk(0, 3, 0) | B_LVL | B_STS);
    cyc(2);
    chk(reg_rdata[28] == 1'b1, "R6 level high sets", 32'(reg_rdata[28]), 32'h1);
    wr(mk(0, 3, 0) | B_LVL | B_STS | C_INT);
    chk(reg_rdata[28] == 1'b0, "R8 clear wins", 32'(reg_rdata[28]), 32'h0);
    cyc(1);
    chk(reg_rdata[28] == 1'b1, "R8 level re-sets", 32'(reg_rdata[28]), 32'h1);
    wr(mk(0, 3, 1) | B_LVL | B_STS | C_INT);
    cyc(3);
    chk(reg_rdata[28] == 1'b0, "R6 level low inactive", 32'(reg_rdata[28]), 32'h0);
    t_edge(0, 1'b0, 1'b1, 1'b1, "R8 setup edge");
    wr(mk(0, 3, 0) | B_STS);
    chk(reg_rdata[28] == 1'b1, "R8 write 0 keeps", 32'(reg_rdata[28]), 32'h1);
    wr(mk(0, 3, 0) | B_STS | C_INT);
    cyc(3);
    chk(reg_rdata[28] == 1'b0, "R8 edge stays clear", 32'(reg_rdata[28]), 32'h0);
  endtask

  task automatic t_deliver;
    set_pad(1'b0);
    wr(mk(0, 3, 0) | B_LVL | B_DLV | C_INT);
    cyc(4);
    chk(irq_out == 1'b0, "R7 idle", 32'(irq_out), 32'h0);
    set_pad(1'b1);
    cyc(4);
    chk(irq_out == 1'b1 && reg_rdata[28] == 1'b0, "R7 delivery only",
        32'({irq_out, reg_rdata[28]}), 32'h2);
    set_pad(1'b0);
    cyc(4);
    chk(irq_out == 1'b0, "R7 level gone", 32'(irq_out), 32'h0);
    t_edge(0, 1'b0, 1'b1, 1'b1, "R7 status only sets");
    chk(irq_out == 1'b0, "R7 status only no irq", 32'(irq_out), 32'h0);
    wr(mk(0, 3, 0) | B_STS | B_DLV);
    chk(irq_out == 1'b1, "R7 status plus delivery", 32'(irq_out), 32'h1);
    wr(mk(0, 3, 0) | B_STS | B_DLV | C_INT);
    chk(irq_out == 1'b0, "R7 cleared", 32'(irq_out), 32'h0);
  endtask

  task automatic t_wake;
    logic [31:0] c;
    c = mk(0, 3, 0) | (32'h5 << 13);
    set_pad(1'b0);
    wr(c | C_WK | C_INT);
    cyc(4);
    set_pad(1'b1);
    cyc(6);
    chk(reg_rdata[29] == 1'b1 && reg_rdata[28] == 1'b0, "R9 wake status",
        32'(reg_rdata[29:28]), 32'h2);
    chk(wake_req == 3'b101, "R9 wake gating", 32'(wake_req), 32'h5);
    wr(c | C_WK);
    chk(wake_req == 3'b000 && reg_rdata[29] == 1'b0, "R9 wake cleared",
        32'({reg_rdata[29], wake_req}), 32'h0);
    wr(mk(0, 3, 0));
    set_pad(1'b0);
    cyc(4);
    set_pad(1'b1);
    cyc(6);
    chk(reg_rdata[29] == 1'b0, "R9 no enables", 32'(reg_rdata[29]), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bypass();
    t_debounce();
    t_glitch();
    t_trig();
    t_w1c();
    t_deliver();
    t_wake();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule